// File: doc/BRIEF.md
# Traffic-Driven Voltage/Frequency Governor

This block picks the operating point of a packet-processing core from the traffic the core is seeing. Each cycle it may receive a packet-arrival strobe together with the packet's size in bits. It adds these sizes over a fixed observation window that is counted in core clock cycles. When a window closes, it compares the total with a threshold that belongs to the current operating level. It then raises or lowers the level by one step, and never moves past the lowest or highest level.

There are five levels, 0 to 4. They run from 400 MHz at 1.1 V up to 600 MHz at 1.3 V, in steps of 50 MHz and 50 mV. The threshold for each level is the top-level threshold scaled by that level's frequency. The thresholds are worked out from parameters at elaboration, so the hardware only compares integers. Every level change costs a settling penalty, during which `busy` is high. While the penalty runs, the window does not advance and arriving traffic is not counted.

Top module: `traffic_vf_governor`

## Requirements
- R1: After reset the level index is 4 (the top level), the outputs show 600 MHz and 1300 mV, and `busy` is low.
- R2: `freqMhz` always equals 400 + 50 × `levelIdx`, and `voltMv` always equals 1100 + 50 × `levelIdx`.
- R3: The threshold for level L is floor(TOP_THRESH_BITS × (8 + L) / 12) bits per window. With a top threshold of 1200, this gives 800, 900, 1000, 1100 and 1200 for levels 0 to 4.
- R4: At a window close, a total above the current threshold raises the level by one. A total below it lowers the level by one.
- R5: A total exactly equal to the current threshold leaves the level unchanged.
- R6: The level never goes below 0 or above 4. A decision that would pass a bound leaves the level unchanged and starts no penalty.
- R7: A window is WINDOW_CYCLES non-busy cycles. A packet in the window's final cycle counts toward that window. The sum restarts from zero for every window.
- R8: Bits are added only in cycles where `pktValid` is high. `pktBits` is ignored when `pktValid` is low.
- R9: A level change drives `busy` high for exactly PENALTY_CYCLES cycles, starting the cycle after the decision. The level holds steady while `busy` is high.
- R10: Packets that arrive while `busy` is high are not counted, and the window counter stays frozen during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | A packet arrives this cycle |
| pktBits | input | PKT_W | Size of the arriving packet in bits |
| levelIdx | output | LVL_W | Current operating level, 0 lowest |
| freqMhz | output | FREQ_W | Frequency of the current level in MHz |
| voltMv | output | VOLT_W | Supply voltage of the current level in mV |
| busy | output | 1 | A transition penalty is in progress |

## Verification
The window totals are placed just above, exactly at and below each level's threshold. This separates a strict comparison from an inclusive one and checks every entry of the derived threshold table on a full climb from level 0 to level 4. Windows with zero traffic drive the level down to the floor, and heavy traffic at the top tests the ceiling, which shows that the clamps start no penalty. Heavy traffic sent during a penalty, followed by an empty window, shows whether frozen cycles leak into the count. A packet placed only in the last cycle of a window, followed by a window below threshold, tells a correct boundary and accumulator clear apart from an off-by-one window.

// File: rtl/gov_pkg.sv
package gov_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic accEn;   // window is running, count arriving packets
    logic accClr;  // last cycle of window: decide and restart sum
  } gov_strobe_t;

  // threshold for one level, scaled by its frequency in step units
  function automatic longint unsigned calcThresh(
    input longint unsigned topBits,
    input int unsigned     minUnits,
    input int unsigned     numLevels,
    input int unsigned     idx);
    longint unsigned topUnits;
    topUnits = longint'(minUnits + numLevels - 1);
    return (topBits * longint'(minUnits + idx)) / topUnits;
  endfunction

endpackage

// File: rtl/gov_datapath.sv
module gov_datapath
  import gov_pkg::*;
#(
  parameter int NUM_LEVELS      = 5,
  parameter int PKT_W           = 16,
  parameter int ACC_W           = 32,
  parameter longint TOP_THRESH_BITS = 33333333,
  parameter int MIN_UNITS       = 8,
  localparam int LVL_W          = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gov_strobe_t       strobe,
  input  logic              pktValid,
  input  logic [PKT_W-1:0]  pktBits,
  input  logic [LVL_W-1:0]  levelIdx,
  output logic              isAbove,
  output logic              isBelow
);

  logic [ACC_W-1:0] thrTab [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_thr
    localparam longint unsigned THR =
      calcThresh(TOP_THRESH_BITS, MIN_UNITS, NUM_LEVELS, g);
    assign thrTab[g] = ACC_W'(THR);
  end

  logic [ACC_W-1:0] accSum;
  logic [ACC_W:0]   sumWide;
  logic [ACC_W-1:0] total;
  logic [ACC_W-1:0] curThr;

  assign sumWide = {1'b0, accSum} + (ACC_W+1)'(pktValid ? pktBits : '0);
  assign total   = sumWide[ACC_W] ? '1 : sumWide[ACC_W-1:0];
  assign curThr  = thrTab[levelIdx];
  assign isAbove = total > curThr;
  assign isBelow = total < curThr;

  always_ff @(posedge clk) begin
    if (!rstN)             accSum <= '0;
    else if (strobe.accClr) accSum <= '0;
    else if (strobe.accEn)  accSum <= total;
  end

endmodule

// File: rtl/gov_control.sv
module gov_control
  import gov_pkg::*;
#(
  parameter int NUM_LEVELS     = 5,
  parameter int WINDOW_CYCLES  = 20000,
  parameter int PENALTY_CYCLES = 6000,
  localparam int LVL_W         = $clog2(NUM_LEVELS),
  localparam int WIN_W         = $clog2(WINDOW_CYCLES),
  localparam int PEN_W         = $clog2(PENALTY_CYCLES + 1),
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isAbove,
  input  logic             isBelow,
  output gov_strobe_t      strobe,
  output logic [LVL_W-1:0] levelIdx,
  output logic             busy
);

  logic [WIN_W-1:0] windowCnt;
  logic [PEN_W-1:0] penaltyCnt;
  logic             windowLast;
  logic             stepUp;
  logic             stepDown;

  assign busy        = penaltyCnt != '0;
  assign windowLast  = windowCnt == WIN_W'(WINDOW_CYCLES - 1);
  assign strobe.accEn  = !busy;
  assign strobe.accClr = !busy && windowLast;
  assign stepUp   = strobe.accClr && isAbove && (levelIdx != LVL_MAX);
  assign stepDown = strobe.accClr && isBelow && (levelIdx != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowCnt  <= '0;
      penaltyCnt <= '0;
      levelIdx   <= LVL_MAX;
    end else begin
      if (busy) begin
        penaltyCnt <= penaltyCnt - 1'b1;
      end else begin
        windowCnt <= windowLast ? '0 : windowCnt + 1'b1;
        if (stepUp || stepDown) penaltyCnt <= PEN_W'(PENALTY_CYCLES);
        if (stepUp)        levelIdx <= levelIdx + 1'b1;
        else if (stepDown) levelIdx <= levelIdx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/traffic_vf_governor.sv
module traffic_vf_governor
  import gov_pkg::*;
#(
  parameter int NUM_LEVELS      = 5,
  parameter int PKT_W           = 16,
  parameter int ACC_W           = 32,
  parameter int WINDOW_CYCLES   = 20000,
  parameter int PENALTY_CYCLES  = 6000,
  parameter longint TOP_THRESH_BITS = 33333333,
  parameter int FREQ_MIN_MHZ    = 400,
  parameter int FREQ_STEP_MHZ   = 50,
  parameter int VOLT_MIN_MV     = 1100,
  parameter int VOLT_STEP_MV    = 50,
  parameter int FREQ_W          = 10,
  parameter int VOLT_W          = 11,
  localparam int LVL_W          = $clog2(NUM_LEVELS),
  localparam int MIN_UNITS      = FREQ_MIN_MHZ / FREQ_STEP_MHZ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [PKT_W-1:0]  pktBits,
  output logic [LVL_W-1:0]  levelIdx,
  output logic [FREQ_W-1:0] freqMhz,
  output logic [VOLT_W-1:0] voltMv,
  output logic              busy
);

  gov_strobe_t strobe;
  logic        isAbove;
  logic        isBelow;

  gov_datapath #(
    .NUM_LEVELS(NUM_LEVELS), .PKT_W(PKT_W), .ACC_W(ACC_W),
    .TOP_THRESH_BITS(TOP_THRESH_BITS), .MIN_UNITS(MIN_UNITS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pktValid(pktValid),
    .pktBits(pktBits), .levelIdx(levelIdx),
    .isAbove(isAbove), .isBelow(isBelow)
  );

  gov_control #(
    .NUM_LEVELS(NUM_LEVELS), .WINDOW_CYCLES(WINDOW_CYCLES),
    .PENALTY_CYCLES(PENALTY_CYCLES)
  ) i_control (
    .clk(clk), .rstN(rstN), .isAbove(isAbove), .isBelow(isBelow),
    .strobe(strobe), .levelIdx(levelIdx), .busy(busy)
  );

  assign freqMhz = FREQ_W'(FREQ_MIN_MHZ) + FREQ_W'(FREQ_STEP_MHZ) * FREQ_W'(levelIdx);
  assign voltMv  = VOLT_W'(VOLT_MIN_MV) + VOLT_W'(VOLT_STEP_MV) * VOLT_W'(levelIdx);

endmodule

// File: rtl/gov_checker.sv
module gov_checker #(
  parameter int NUM_LEVELS     = 5,
  parameter int PENALTY_CYCLES = 6000,
  localparam int LVL_W         = $clog2(NUM_LEVELS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] levelIdx,
  input logic             busy
);

  int busyRun;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyRun <= 0;
    else                busyRun <= busyRun + 1;
  end

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(levelIdx) <= NUM_LEVELS - 1);

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelIdx != $past(levelIdx)) |->
      (int'(levelIdx) == int'($past(levelIdx)) + 1 ||
       int'(levelIdx) + 1 == int'($past(levelIdx))));

  // R9
  change_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelIdx != $past(levelIdx)) |-> busy);

  // R9
  hold_in_penalty_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(levelIdx));

  // R9
  penalty_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == PENALTY_CYCLES);

endmodule

bind traffic_vf_governor gov_checker #(
  .NUM_LEVELS(NUM_LEVELS), .PENALTY_CYCLES(PENALTY_CYCLES)
) i_gov_checker (
  .clk(clk), .rstN(rstN), .levelIdx(levelIdx), .busy(busy)
);

// File: tb/test_traffic_vf_governor.sv
`timescale 1ns/1ps
module test_traffic_vf_governor;

  localparam int WIN  = 100;
  localparam int PEN  = 20;
  localparam int TOP  = 1200;
  localparam int NLVL = 5;

  logic       clk = 0;
  logic       rstN = 0;
  logic       pktValid = 0;
  logic [15:0] pktBits = '0;
  logic [2:0] levelIdx;
  logic [9:0] freqMhz;
  logic [10:0] voltMv;
  logic       busy;

  always #2.5 clk = ~clk;

  traffic_vf_governor #(
    .NUM_LEVELS(NLVL), .WINDOW_CYCLES(WIN), .PENALTY_CYCLES(PEN),
    .TOP_THRESH_BITS(TOP)
  ) i_traffic_vf_governor (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktBits(pktBits),
    .levelIdx(levelIdx), .freqMhz(freqMhz), .voltMv(voltMv), .busy(busy)
  );

  typedef struct {
    int    lvl;
    bit    bsy;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  int   curLvl = NLVL - 1;
  bit   finished = 0;

  function automatic int thrOf(int l);
    return TOP * (8 + l) / 12; // R3
  endfunction

  // monitor: pop expected items and compare with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (int'(levelIdx) != e.lvl || busy != e.bsy) begin
          errors++;
          $display("FAIL %s: level=%0d busy=%0b expected level=%0d busy=%0b",
                   e.tag, levelIdx, busy, e.lvl, e.bsy);
        end
        checks++;
        if (int'(freqMhz) != 400 + 50 * e.lvl || int'(voltMv) != 1100 + 50 * e.lvl) begin
          errors++;
          $display("FAIL R2 (%s): freq=%0d volt=%0d expected freq=%0d volt=%0d",
                   e.tag, freqMhz, voltMv, 400 + 50 * e.lvl, 1100 + 50 * e.lvl);
        end
      end
    end
  end

  // driver: one window of traffic, then the penalty if a change is expected
  task automatic runWindow(input int nPkts, input int bits, input bit atEnd,
                           input int junk, input string tag);
    int total;
    int newLvl;
    total  = nPkts * bits;
    newLvl = curLvl;
    if (total > thrOf(curLvl) && curLvl < NLVL - 1) newLvl = curLvl + 1;
    else if (total < thrOf(curLvl) && curLvl > 0)   newLvl = curLvl - 1;
    for (int c = 0; c < WIN; c++) begin
      bit on;
      on = atEnd ? (c == WIN - 1) : (c < nPkts);
      pktValid = on;
      pktBits  = on ? 16'(bits) : 16'(junk);
      @(negedge clk);
    end
    pktValid = 0;
    pktBits  = '0;
    expQ.push_back('{newLvl, newLvl != curLvl, tag});
    if (newLvl != curLvl) begin
      // heavy traffic during the penalty must not be counted (R10)
      for (int c = 0; c < PEN; c++) begin
        pktValid = 1;
        pktBits  = 16'd5000;
        @(negedge clk);
      end
      pktValid = 0;
      pktBits  = '0;
      expQ.push_back('{newLvl, 1'b0, "R9"});
    end
    curLvl = newLvl;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    expQ.push_back('{NLVL - 1, 1'b0, "R1"});
    runWindow(13, 100, 0, 0, "R6");    // 1300 above top threshold, ceiling
    runWindow(12, 100, 0, 0, "R5");    // exactly 1200
    runWindow(10, 100, 0, 0, "R4");    // 1000 below, drop to 3
    runWindow(11, 100, 0, 0, "R5");    // exactly 1100 at level 3
    runWindow(0, 0, 0, 9999, "R8");    // invalid strobes carry junk size
    runWindow(0, 0, 0, 0, "R10");      // penalty traffic ignored, drop to 1
    runWindow(0, 0, 0, 0, "R4");       // drop to 0
    runWindow(0, 0, 0, 0, "R6");       // floor
    runWindow(8, 100, 0, 0, "R5");     // exactly 800 at level 0
    runWindow(1, 801, 1, 0, "R7");     // only last-cycle packet, up to 1
    runWindow(1, 850, 0, 0, "R7");     // 850 < 900 only if sum restarted
    runWindow(1, 801, 0, 0, "R3");     // level 0 -> 1
    runWindow(1, 900, 0, 0, "R3");     // equal 900 at level 1
    runWindow(1, 901, 0, 0, "R3");     // -> 2
    runWindow(1, 1001, 0, 0, "R3");    // -> 3
    runWindow(1, 1099, 0, 0, "R3");    // just below 1100 -> 2
    runWindow(1, 1001, 0, 0, "R3");    // -> 3
    runWindow(1, 1101, 0, 0, "R3");    // -> 4
    runWindow(1, 1199, 0, 0, "R3");    // just below 1200 -> 3
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule